// File: doc/BRIEF.md
# Weighted Centre-of-Gravity Defuzzifier

This block turns the weighted consequent terms of a fuzzy controller into crisp output values, one output variable after another. Each output variable owns a list of consequent entries. Every entry carries a stored area, a stored product of area and centroid abscissa (both for the lowest truth level), a 4-bit weight taken from rule evaluation, and a flag marking the last entry of the list. The block scales both stored terms by the weight and adds them into two accumulators that run side by side. A sequential divider then divides the weighted centroid sum by the weighted area sum, giving a 10-bit value.

A run starts with a one-cycle `start` pulse. The block reads the table through a simple synchronous port: it raises `rdEn` with an address, and the entry must be present on the table inputs during the next cycle. Each finished value appears on `outData` with its variable number on `outIdx`, marked by a one-cycle `outStb`. `endProc` is high while a run is in progress. `newProc` drops one value early, so the upstream stage can begin its next acquisition while the last value is still being computed.

Top module: `defuz_cog`

## Requirements
- R1: Each output value is floor( sum(w·AC) / sum(w·A) ) over the entries of that output variable, where AC is `tabAreaCent`, A is `tabArea` and w is `tabOmega`.
- R2: Each entry's two stored terms are multiplied by its own 4-bit weight before accumulation. A weight of 0 removes the entry from both sums.
- R3: When the weighted area sum is zero, the output value is 0.
- R4: When the quotient would be 1024 or more, the output value is 1023.
- R5: A run yields cfgLastOut+1 values (cfgLastOut holds the number of variables minus one), in index order 0,1,2,… on `outIdx`. `outStb` is high for exactly one clock per value.
- R6: `outData` and `outIdx` change only on the clock edge where `outStb` rises, and they hold their values until the next strobe.
- R7: `newProc` rises with `endProc` when a run is accepted. It falls on the edge that ends the strobe of variable cfgLastOut-1. With a single variable, it falls on the edge that ends the only strobe.
- R8: `endProc` rises on the edge that accepts `start`, stays high throughout the run, and falls on the edge that ends the last strobe.
- R9: A `start` pulse while `endProc` is high is ignored: the number of values and their content are unchanged, and no further strobe follows the run.
- R10: The entry list of a variable ends at the first entry with `tabLast` = 1, or after 16 entries if none is flagged.
- R11: After reset, `outStb`, `newProc`, `endProc` and `rdEn` are low, and `outData` and `outIdx` are 0.
- R12: `rdAddr` is {variable index (upper 4 bits), entry index (lower 4 bits)}. The entry is sampled one cycle after `rdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a run |
| cfgLastOut | input | 4 | Number of output variables minus one, sampled at start |
| rdEn | output | 1 | Table read request |
| rdAddr | output | 8 | Table address {variable, entry} |
| tabAreaCent | input | 18 | Stored area × centroid of the entry |
| tabArea | input | 8 | Stored area of the entry |
| tabOmega | input | 4 | Weight of the entry |
| tabLast | input | 1 | Entry is the last of its variable |
| outStb | output | 1 | One-cycle strobe for a new value |
| outData | output | 10 | Crisp output value |
| outIdx | output | 4 | Index of the variable on outData |
| newProc | output | 1 | Upstream may start a new acquisition when low |
| endProc | output | 1 | High while the run is in progress |

## Verification
The tables mix entry lists of one to five entries with assorted weights, so a wrong scaling or a missed entry changes the quotient. A full sixteen-variable run with unterminated lists probes the entry limit and the address split. Separate variables with all weights zero and with a tiny area under a large centroid product separate the zero-denominator path from saturation. Runs with one and with several variables tell apart where `newProc` falls relative to `endProc`, and a `start` pulse injected mid-run shows whether a busy block restarts.

// File: rtl/defuz_pkg.sv
package defuz_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrAcc;
    logic accEn;
    logic divStart;
    logic divStep;
    logic latchOut;
  } dfCtrl_t;
endpackage

// File: rtl/defuz_ctrl.sv
module defuz_ctrl
  import defuz_pkg::*;
#(
  parameter int OUT_IDX_W = 4,
  parameter int MF_IDX_W  = 4,
  parameter int OUT_W     = 10,
  localparam int STEP_W   = $clog2(OUT_W),
  localparam int ADDR_W   = OUT_IDX_W + MF_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [OUT_IDX_W-1:0] cfgLastOut,
  input  logic                 tabLast,
  output logic                 rdEn,
  output logic [ADDR_W-1:0]    rdAddr,
  output dfCtrl_t              ctrl,
  output logic [STEP_W-1:0]    stepIdx,
  output logic                 stb,
  output logic [OUT_IDX_W-1:0] outIdx,
  output logic                 newProc,
  output logic                 endProc
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_ACC, S_DIVINIT, S_DIVRUN, S_EMIT, S_STBEND
  } dfState_e;

  dfState_e             state;
  logic [OUT_IDX_W-1:0] outCnt;
  logic [OUT_IDX_W-1:0] lastOutQ;
  logic [MF_IDX_W-1:0]  mfIdx;
  logic [STEP_W-1:0]    stepCnt;
  logic                 stbQ;
  logic [OUT_IDX_W-1:0] outIdxQ;
  logic                 npQ;
  logic                 epQ;
  logic                 isLastOut;
  logic                 isPenult;

  assign isLastOut = (outCnt == lastOutQ);
  assign isPenult  = (outCnt == lastOutQ - 1'b1);

  always_comb begin
    ctrl          = '0;
    ctrl.clrAcc   = (state == S_IDLE && start) || (state == S_STBEND && !isLastOut);
    ctrl.accEn    = (state == S_ACC);
    ctrl.divStart = (state == S_DIVINIT);
    ctrl.divStep  = (state == S_DIVRUN);
    ctrl.latchOut = (state == S_EMIT);
  end

  assign rdEn    = (state == S_FETCH);
  assign rdAddr  = {outCnt, mfIdx};
  assign stepIdx = stepCnt;
  assign stb     = stbQ;
  assign outIdx  = outIdxQ;
  assign newProc = npQ;
  assign endProc = epQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      outCnt   <= '0;
      lastOutQ <= '0;
      mfIdx    <= '0;
      stepCnt  <= '0;
      stbQ     <= 1'b0;
      outIdxQ  <= '0;
      npQ      <= 1'b0;
      epQ      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            lastOutQ <= cfgLastOut;
            outCnt   <= '0;
            mfIdx    <= '0;
            npQ      <= 1'b1;
            epQ      <= 1'b1;
            state    <= S_FETCH;
          end
        end
        S_FETCH: state <= S_ACC;
        S_ACC: begin
          if (tabLast || mfIdx == '1) begin
            state <= S_DIVINIT;
          end else begin
            mfIdx <= mfIdx + 1'b1;
            state <= S_FETCH;
          end
        end
        S_DIVINIT: begin
          stepCnt <= STEP_W'(OUT_W - 1);
          state   <= S_DIVRUN;
        end
        S_DIVRUN: begin
          if (stepCnt == '0) state <= S_EMIT;
          else               stepCnt <= stepCnt - 1'b1;
        end
        S_EMIT: begin
          stbQ    <= 1'b1;
          outIdxQ <= outCnt;
          state   <= S_STBEND;
        end
        S_STBEND: begin
          stbQ <= 1'b0;
          if (isLastOut) begin
            npQ   <= 1'b0;
            epQ   <= 1'b0;
            state <= S_IDLE;
          end else begin
            if (isPenult) npQ <= 1'b0;
            outCnt <= outCnt + 1'b1;
            mfIdx  <= '0;
            state  <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: strobe lasts one clock
  p_stb_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |=> !stbQ);
  // R6: index holds between strobes
  p_idx_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stbQ |-> $stable(outIdxQ));
  // R7: newProc never outlives endProc
  p_np_within_ep_r7: assert property (@(posedge clk) disable iff (!rstN)
    !epQ |-> !npQ);
  // R7: newProc only falls as a strobe ends
  p_np_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(npQ) |-> $past(stbQ));
  // R8: strobes only inside a run
  p_stb_in_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |-> epQ);
endmodule

// File: rtl/defuz_datapath.sv
module defuz_datapath
  import defuz_pkg::*;
#(
  parameter int AC_W     = 18,
  parameter int AR_W     = 8,
  parameter int OM_W     = 4,
  parameter int MF_IDX_W = 4,
  parameter int OUT_W    = 10,
  localparam int STEP_W  = $clog2(OUT_W),
  localparam int NUM_W   = AC_W + OM_W + MF_IDX_W,
  localparam int DEN_W   = AR_W + OM_W + MF_IDX_W,
  localparam int CMP_W   = ((NUM_W > DEN_W + OUT_W) ? NUM_W : DEN_W + OUT_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dfCtrl_t           ctrl,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic [AC_W-1:0]   tabAreaCent,
  input  logic [AR_W-1:0]   tabArea,
  input  logic [OM_W-1:0]   tabOmega,
  output logic [OUT_W-1:0]  outData
);
  logic [NUM_W-1:0] numAcc;
  logic [DEN_W-1:0] denAcc;
  logic [NUM_W-1:0] remQ;
  logic [OUT_W-1:0] quotQ;
  logic             specialQ;
  logic [OUT_W-1:0] dataQ;

  logic [NUM_W-1:0] acProd;
  logic [DEN_W-1:0] arProd;
  logic [CMP_W-1:0] shiftedDen;
  logic             fits;
  logic             satHit;
  logic             denZero;

  assign acProd     = NUM_W'(tabAreaCent) * NUM_W'(tabOmega);
  assign arProd     = DEN_W'(tabArea) * DEN_W'(tabOmega);
  assign shiftedDen = CMP_W'(denAcc) << stepIdx;
  assign fits       = CMP_W'(remQ) >= shiftedDen;
  assign satHit     = CMP_W'(numAcc) >= (CMP_W'(denAcc) << OUT_W);
  assign denZero    = (denAcc == '0);

  // two accumulators side by side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numAcc <= '0;
      denAcc <= '0;
    end else if (ctrl.clrAcc) begin
      numAcc <= '0;
      denAcc <= '0;
    end else if (ctrl.accEn) begin
      numAcc <= numAcc + acProd;
      denAcc <= denAcc + arProd;
    end
  end

  // restoring divider, one quotient bit per step, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ     <= '0;
      quotQ    <= '0;
      specialQ <= 1'b0;
    end else if (ctrl.divStart) begin
      if (denZero) begin
        quotQ    <= '0;
        specialQ <= 1'b1;
      end else if (satHit) begin
        quotQ    <= '1;
        specialQ <= 1'b1;
      end else begin
        remQ     <= numAcc;
        quotQ    <= '0;
        specialQ <= 1'b0;
      end
    end else if (ctrl.divStep && !specialQ && fits) begin
      remQ           <= remQ - NUM_W'(shiftedDen);
      quotQ[stepIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (ctrl.latchOut) dataQ <= quotQ;
  end

  assign outData = dataQ;

  // R1: sums never wrap within one variable
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accEn |=> (numAcc >= $past(numAcc)) && (denAcc >= $past(denAcc)));
  // R3: empty denominator gives zero
  p_zero_den_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.divStart && denZero) |=> (quotQ == '0));
  // R6: data holds unless latched
  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.latchOut |=> $stable(dataQ));
endmodule

// File: rtl/defuz_cog.sv
module defuz_cog
  import defuz_pkg::*;
#(
  parameter int OUT_IDX_W = 4,
  parameter int MF_IDX_W  = 4,
  parameter int AC_W      = 18,
  parameter int AR_W      = 8,
  parameter int OM_W      = 4,
  parameter int OUT_W     = 10,
  localparam int STEP_W   = $clog2(OUT_W),
  localparam int ADDR_W   = OUT_IDX_W + MF_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [OUT_IDX_W-1:0] cfgLastOut,
  output logic                 rdEn,
  output logic [ADDR_W-1:0]    rdAddr,
  input  logic [AC_W-1:0]      tabAreaCent,
  input  logic [AR_W-1:0]      tabArea,
  input  logic [OM_W-1:0]      tabOmega,
  input  logic                 tabLast,
  output logic                 outStb,
  output logic [OUT_W-1:0]     outData,
  output logic [OUT_IDX_W-1:0] outIdx,
  output logic                 newProc,
  output logic                 endProc
);
  dfCtrl_t           ctrl;
  logic [STEP_W-1:0] stepIdx;

  defuz_ctrl #(
    .OUT_IDX_W(OUT_IDX_W), .MF_IDX_W(MF_IDX_W), .OUT_W(OUT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgLastOut(cfgLastOut),
    .tabLast(tabLast), .rdEn(rdEn), .rdAddr(rdAddr), .ctrl(ctrl),
    .stepIdx(stepIdx), .stb(outStb), .outIdx(outIdx),
    .newProc(newProc), .endProc(endProc)
  );

  defuz_datapath #(
    .AC_W(AC_W), .AR_W(AR_W), .OM_W(OM_W), .MF_IDX_W(MF_IDX_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stepIdx(stepIdx),
    .tabAreaCent(tabAreaCent), .tabArea(tabArea), .tabOmega(tabOmega),
    .outData(outData)
  );
endmodule

// File: tb/tb_defuz_cog.sv
module tb_defuz_cog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfgLastOut = '0;
  logic        rdEn;
  logic [7:0]  rdAddr;
  logic [17:0] tabAreaCent = '0;
  logic [7:0]  tabArea = '0;
  logic [3:0]  tabOmega = '0;
  logic        tabLast = 1'b0;
  logic        outStb;
  logic [9:0]  outData;
  logic [3:0]  outIdx;
  logic        newProc;
  logic        endProc;

  int checks = 0;
  int errors = 0;

  logic [17:0] mAC   [16][16];
  logic [7:0]  mAR   [16][16];
  logic [3:0]  mOm   [16][16];
  logic        mLast [16][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  defuz_cog dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgLastOut(cfgLastOut),
    .rdEn(rdEn), .rdAddr(rdAddr), .tabAreaCent(tabAreaCent), .tabArea(tabArea),
    .tabOmega(tabOmega), .tabLast(tabLast), .outStb(outStb), .outData(outData),
    .outIdx(outIdx), .newProc(newProc), .endProc(endProc)
  );

  // synchronous table model, R12 address split
  always @(posedge clk) begin
    if (rdEn) begin
      tabAreaCent <= mAC[rdAddr[7:4]][rdAddr[3:0]];
      tabArea     <= mAR[rdAddr[7:4]][rdAddr[3:0]];
      tabOmega    <= mOm[rdAddr[7:4]][rdAddr[3:0]];
      tabLast     <= mLast[rdAddr[7:4]][rdAddr[3:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: short terminated lists; mode 1: sixteen entries, no flag (R10)
  task automatic fillTable(input int seed, input int mode);
    for (int o = 0; o < 16; o++) begin
      for (int m = 0; m < 16; m++) begin
        int area = 1 + ((o*13 + m*7 + seed) % 255);
        int cent = (o*97 + m*31 + seed*5) % 1024;
        mAR[o][m]   = 8'(area);
        mAC[o][m]   = 18'(area * cent);
        mOm[o][m]   = 4'((o + m*3 + seed) % 16);
        mLast[o][m] = (mode == 0) ? (m == ((o + seed) % 5)) : 1'b0;
      end
    end
  endtask

  function automatic int expOf(input int o);
    longint num = 0;
    longint den = 0;
    for (int m = 0; m < 16; m++) begin
      num += longint'(mAC[o][m]) * longint'(mOm[o][m]);
      den += longint'(mAR[o][m]) * longint'(mOm[o][m]);
      if (mLast[o][m]) break;
    end
    if (den == 0) return 0;
    if (num / den > 1023) return 1023;
    return int'(num / den);
  endfunction

  // one run; pokeAt >= 0 injects a start pulse that must be ignored (R9)
  task automatic runSeq(input int lastOut, input int pokeAt, input string tag);
    int seen = 0;
    int cyc = 0;
    bit prevStb = 0;
    int prevIdx = 0;
    bit unstable = 0;
    logic [9:0] holdD = '0;
    logic [3:0] holdI = '0;
    bit badData = 0;
    @(negedge clk);
    cfgLastOut = 4'(lastOut);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(endProc && newProc, {tag, " R8 R7 flags rise on start"}, {endProc, newProc}, 3);
    while (cyc < 5000) begin
      if (cyc == pokeAt) begin start = 1'b1; cfgLastOut = 4'd15; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (prevStb) begin
        chk(newProc == (prevIdx < lastOut - 1), {tag, " R7 newProc after strobe"},
            newProc, (prevIdx < lastOut - 1));
        chk(endProc == (prevIdx < lastOut), {tag, " R8 endProc after strobe"},
            endProc, (prevIdx < lastOut));
      end
      if (outStb) begin
        chk(outIdx == 4'(seen), {tag, " R5 index order"}, outIdx, seen);
        chk(outData == 10'(expOf(seen)), {tag, " R1 value"}, outData, expOf(seen));
        if (outData != 10'(expOf(seen))) badData = 1;
        chk(endProc, {tag, " R8 busy during strobe"}, endProc, 1);
        holdD = outData;
        holdI = outIdx;
        prevIdx = seen;
        seen++;
      end else if (seen > 0 && (outData != holdD || outIdx != holdI)) begin
        unstable = 1;
      end
      if (prevStb && outStb) unstable = 1;
      prevStb = outStb;
      if (!endProc) break;
    end
    start = 1'b0;
    chk(seen == lastOut + 1, {tag, " R5 strobe count"}, seen, lastOut + 1);
    chk(!unstable, {tag, " R6 hold between strobes"}, unstable, 0);
    chk(!badData, {tag, " R2 weighted sums"}, badData, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (outStb || endProc) unstable = 1;
    end
    chk(!unstable, {tag, " R9 quiet after run"}, unstable, 0);
  endtask

  task automatic t_reset();
    chk(!outStb && !newProc && !endProc && !rdEn, "R11 reset flags",
        {outStb, newProc, endProc, rdEn}, 0);
    chk(outData == 0 && outIdx == 0, "R11 reset data", outData, 0);
  endtask

  task automatic t_basic();
    fillTable(3, 0);
    runSeq(3, -1, "basic");
    fillTable(8, 0);
    runSeq(6, -1, "basic2");
  endtask

  task automatic t_single();
    fillTable(1, 0);
    runSeq(0, -1, "single");
  endtask

  task automatic t_corner();
    fillTable(2, 0);
    // out0: all weights zero -> R3
    for (int m = 0; m < 16; m++) mOm[0][m] = 4'd0;
    // out1: one entry, tiny area, big product -> R4
    mAR[1][0] = 8'd1; mAC[1][0] = 18'd200000; mOm[1][0] = 4'd1; mLast[1][0] = 1'b1;
    // out2: extreme weights and areas
    for (int m = 0; m < 16; m++) begin
      mAR[2][m] = 8'd255; mAC[2][m] = 18'(255 * 1023); mOm[2][m] = 4'd15;
      mLast[2][m] = (m == 3);
    end
    chk(expOf(0) == 0 && expOf(1) == 1023 && expOf(2) == 1023, "R3 R4 model", expOf(1), 1023);
    runSeq(2, -1, "corner R3 R4");
  endtask

  task automatic t_full();
    fillTable(5, 1);
    runSeq(15, -1, "full R10 R12");
  endtask

  task automatic t_ignore();
    fillTable(4, 0);
    runSeq(2, 20, "ignore R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_single();
    t_corner();
    t_full();
    t_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule